// File: doc/BRIEF.md
# Second-Level Cache Start-Up Sequencer

This block brings a second-level cache online once the chip leaves reset. Through a register port it reads a feature register and turns on the bit that stops the cache from prefetching. When the feature register shows the cache is still off, the block runs the enable sequence:

1. It takes both first-level caches out of service. It records which of them was running.
2. It invalidates the whole second-level cache.
3. It sets the enable bit.
4. It brings back the first-level caches that were running before.

Register writes never clobber the other bits of a register. The block reads the register, changes only the bits it owns, and writes the result back.

The block drives two kinds of traffic, each with a request/acknowledge handshake:

- **Register port.** A single-bit select addresses the feature register or the first-level cache control register.
- **Maintenance lines.** There are three of them: flush the L1 data cache, invalidate the L1 instruction cache, and invalidate the second-level cache.

The sequence starts by itself on the first clock after reset is released. Once it is finished, `done` stays high until the next reset.

Top module: `l2_enable_seq`

## Requirements
- R1: While `rst` is high, `reg_req`, every bit of `mnt_req` and `done` are low. The first operation after reset is released is a read of the feature register.
- R2: Bit 24 of the feature register stops prefetch. If the first read returns it as 0, the block writes the feature register back with bit 24 set and every other bit unchanged. If it reads as 1, no write follows.
- R3: The feature register is read a second time. If bit 22 (cache enable) is 1 in that read, the block issues no further operations and raises `done`.
- R4: Bit 2 of the control register marks the L1 data cache as on. If the control read shows it set, the block flushes the data cache on `mnt_req[0]`, then writes the control register with bit 2 cleared and every other bit preserved.
- R5: Bit 12 of the control register marks the L1 instruction cache as on. If a fresh control read shows it set, the block writes the control register with bit 12 cleared, then invalidates the instruction cache on `mnt_req[1]`.
- R6: The second-level invalidate on `mnt_req[2]` follows the point where both L1 caches are off. The enable write to the feature register comes after that invalidate. It carries the value from the second feature read with bit 22 set.
- R7: After the enable write, the block restores the L1 caches with a read-modify-write of the control register. The instruction cache (bit 12) comes back before the data cache (bit 2), and each is restored only if it was on before.
- R8: At most one request (`reg_req` or a `mnt_req` bit) is high at any time. A request and its `reg_we`, `reg_sel` and `reg_wdata` stay unchanged until acknowledged. Each clock with request and acknowledge both high completes exactly one operation.
- R9: `done` rises after the last operation, stays high until reset, and no request is raised while it is high.
- R10: On the register port, `reg_sel` = 0 addresses the feature register and `reg_sel` = 1 addresses the L1 control register. Read data is taken from `reg_rdata` in the clock where `reg_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_sel | output | 1 | 0 = feature register, 1 = L1 control register |
| reg_wdata | output | DW | Write data |
| reg_rdata | input | DW | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Register access acknowledge |
| mnt_req | output | 3 | Maintenance requests: [0] L1D flush, [1] L1I invalidate, [2] L2 invalidate |
| mnt_ack | input | 3 | Maintenance acknowledges, per line |
| done | output | 1 | Sequence finished, sticky until reset |

## Verification
The assertions check the handshake discipline on every cycle: a single outstanding request, requests and their fields held until acknowledged, and `done` staying high with the ports quiet afterwards. They also check the safety rule around the enable write. The checker follows the L1 control values as they pass over the port, and it requires both L1 caches to be off and the L2 invalidate to have been seen before any write that sets the enable bit.

Only the bench scenarios can show that the sequence is exact: the order of the operations, that conditional steps are skipped, that the read-modify-write values are correct and that the final register state is correct. The bench sweeps every combination of the four controlling bits at several acknowledge latencies.

// File: rtl/l2en_pkg.sv
package l2en_pkg;

  localparam int unsigned MNT_NUM       = 3;
  localparam int unsigned MNT_L1D_FLUSH = 0;
  localparam int unsigned MNT_L1I_INV   = 1;
  localparam int unsigned MNT_L2_INV    = 2;

  localparam logic SEL_FEAT = 1'b0;
  localparam logic SEL_CTL  = 1'b1;

  typedef enum logic [4:0] {
    S_BOOT,
    S_RD_PF,
    S_WR_PF,
    S_RD_EN,
    S_RD_CTL_D,
    S_FLUSH_D,
    S_WR_D_OFF,
    S_RD_CTL_I,
    S_WR_I_OFF,
    S_INV_I,
    S_INV_L2,
    S_WR_EN,
    S_RD_CTL_RI,
    S_WR_I_ON,
    S_RD_CTL_RD,
    S_WR_D_ON,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/l2en_hs_chan.sv
module l2en_hs_chan (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic ack,
  output logic req,
  output logic fin
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
    end else if (issue) begin
      req <= 1'b1;
    end else if (ack) begin
      req <= 1'b0;
    end
  end

  assign fin = req & ack;

endmodule

// File: rtl/l2en_regport.sv
module l2en_regport #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          issue_we,
  input  logic          issue_sel,
  input  logic [DW-1:0] issue_wdata,
  output logic          reg_req,
  output logic          reg_we,
  output logic          reg_sel,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack,
  output logic          fin
);

  l2en_hs_chan u_hs (
    .clk   (clk),
    .rst   (rst),
    .issue (issue),
    .ack   (reg_ack),
    .req   (reg_req),
    .fin   (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we    <= 1'b0;
      reg_sel   <= 1'b0;
      reg_wdata <= '0;
    end else if (issue) begin
      reg_we    <= issue_we;
      reg_sel   <= issue_sel;
      reg_wdata <= issue_wdata;
    end
  end

endmodule

// File: rtl/l2en_seq.sv
module l2en_seq
  import l2en_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned PF_BIT = 24,
  parameter int unsigned EN_BIT = 22,
  parameter int unsigned DC_BIT = 2,
  parameter int unsigned IC_BIT = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fin,
  input  logic [DW-1:0]      rdata,
  output logic               r_iss,
  output logic               r_we,
  output logic               r_sel,
  output logic [DW-1:0]      r_wd,
  output logic [MNT_NUM-1:0] m_iss,
  output logic               done_q
);

  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] PF_M = ONE << PF_BIT;
  localparam logic [DW-1:0] EN_M = ONE << EN_BIT;
  localparam logic [DW-1:0] DC_M = ONE << DC_BIT;
  localparam logic [DW-1:0] IC_M = ONE << IC_BIT;

  seq_state_e st, nxt;
  logic [DW-1:0] feat_q;
  logic [DW-1:0] ctl_q;
  logic          d_was;
  logic          i_was;

  always_comb begin
    nxt   = st;
    r_iss = 1'b0;
    r_we  = 1'b0;
    r_sel = SEL_FEAT;
    r_wd  = '0;
    m_iss = '0;
    case (st)
      S_BOOT: begin
        r_iss = 1'b1;
        nxt   = S_RD_PF;
      end
      S_RD_PF: if (fin) begin
        r_iss = 1'b1;
        if ((rdata & PF_M) == '0) begin
          r_we = 1'b1;
          r_wd = rdata | PF_M;
          nxt  = S_WR_PF;
        end else begin
          nxt = S_RD_EN;
        end
      end
      S_WR_PF: if (fin) begin
        r_iss = 1'b1;
        nxt   = S_RD_EN;
      end
      S_RD_EN: if (fin) begin
        if ((rdata & EN_M) != '0) begin
          nxt = S_DONE;
        end else begin
          r_iss = 1'b1;
          r_sel = SEL_CTL;
          nxt   = S_RD_CTL_D;
        end
      end
      S_RD_CTL_D: if (fin) begin
        if ((rdata & DC_M) != '0) begin
          m_iss[MNT_L1D_FLUSH] = 1'b1;
          nxt = S_FLUSH_D;
        end else begin
          r_iss = 1'b1;
          r_sel = SEL_CTL;
          nxt   = S_RD_CTL_I;
        end
      end
      S_FLUSH_D: if (fin) begin
        r_iss = 1'b1;
        r_we  = 1'b1;
        r_sel = SEL_CTL;
        r_wd  = ctl_q & ~DC_M;
        nxt   = S_WR_D_OFF;
      end
      S_WR_D_OFF: if (fin) begin
        r_iss = 1'b1;
        r_sel = SEL_CTL;
        nxt   = S_RD_CTL_I;
      end
      S_RD_CTL_I: if (fin) begin
        if ((rdata & IC_M) != '0) begin
          r_iss = 1'b1;
          r_we  = 1'b1;
          r_sel = SEL_CTL;
          r_wd  = rdata & ~IC_M;
          nxt   = S_WR_I_OFF;
        end else begin
          m_iss[MNT_L2_INV] = 1'b1;
          nxt = S_INV_L2;
        end
      end
      S_WR_I_OFF: if (fin) begin
        m_iss[MNT_L1I_INV] = 1'b1;
        nxt = S_INV_I;
      end
      S_INV_I: if (fin) begin
        m_iss[MNT_L2_INV] = 1'b1;
        nxt = S_INV_L2;
      end
      S_INV_L2: if (fin) begin
        r_iss = 1'b1;
        r_we  = 1'b1;
        r_wd  = feat_q | EN_M;
        nxt   = S_WR_EN;
      end
      S_WR_EN: if (fin) begin
        if (i_was) begin
          r_iss = 1'b1;
          r_sel = SEL_CTL;
          nxt   = S_RD_CTL_RI;
        end else if (d_was) begin
          r_iss = 1'b1;
          r_sel = SEL_CTL;
          nxt   = S_RD_CTL_RD;
        end else begin
          nxt = S_DONE;
        end
      end
      S_RD_CTL_RI: if (fin) begin
        r_iss = 1'b1;
        r_we  = 1'b1;
        r_sel = SEL_CTL;
        r_wd  = rdata | IC_M;
        nxt   = S_WR_I_ON;
      end
      S_WR_I_ON: if (fin) begin
        if (d_was) begin
          r_iss = 1'b1;
          r_sel = SEL_CTL;
          nxt   = S_RD_CTL_RD;
        end else begin
          nxt = S_DONE;
        end
      end
      S_RD_CTL_RD: if (fin) begin
        r_iss = 1'b1;
        r_we  = 1'b1;
        r_sel = SEL_CTL;
        r_wd  = rdata | DC_M;
        nxt   = S_WR_D_ON;
      end
      S_WR_D_ON: if (fin) begin
        nxt = S_DONE;
      end
      S_DONE: nxt = S_DONE;
      default: nxt = S_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_BOOT;
      feat_q <= '0;
      ctl_q  <= '0;
      d_was  <= 1'b0;
      i_was  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (nxt == S_DONE);
      if (st == S_RD_EN && fin) begin
        feat_q <= rdata;
      end
      if (st == S_RD_CTL_D && fin) begin
        ctl_q <= rdata;
        d_was <= (rdata & DC_M) != '0;
      end
      if (st == S_RD_CTL_I && fin) begin
        i_was <= (rdata & IC_M) != '0;
      end
    end
  end

endmodule

// File: rtl/l2_enable_seq.sv
module l2_enable_seq
  import l2en_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned PF_BIT = 24,
  parameter int unsigned EN_BIT = 22,
  parameter int unsigned DC_BIT = 2,
  parameter int unsigned IC_BIT = 12
) (
  input  logic               clk,
  input  logic               rst,
  output logic               reg_req,
  output logic               reg_we,
  output logic               reg_sel,
  output logic [DW-1:0]      reg_wdata,
  input  logic [DW-1:0]      reg_rdata,
  input  logic               reg_ack,
  output logic [MNT_NUM-1:0] mnt_req,
  input  logic [MNT_NUM-1:0] mnt_ack,
  output logic               done
);

  logic               r_iss;
  logic               r_we;
  logic               r_sel;
  logic [DW-1:0]      r_wd;
  logic [MNT_NUM-1:0] m_iss;
  logic               reg_fin;
  logic [MNT_NUM-1:0] mnt_fin;
  logic               any_fin;

  l2en_seq #(
    .DW     (DW),
    .PF_BIT (PF_BIT),
    .EN_BIT (EN_BIT),
    .DC_BIT (DC_BIT),
    .IC_BIT (IC_BIT)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .fin    (any_fin),
    .rdata  (reg_rdata),
    .r_iss  (r_iss),
    .r_we   (r_we),
    .r_sel  (r_sel),
    .r_wd   (r_wd),
    .m_iss  (m_iss),
    .done_q (done)
  );

  l2en_regport #(.DW(DW)) u_reg (
    .clk         (clk),
    .rst         (rst),
    .issue       (r_iss),
    .issue_we    (r_we),
    .issue_sel   (r_sel),
    .issue_wdata (r_wd),
    .reg_req     (reg_req),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .reg_ack     (reg_ack),
    .fin         (reg_fin)
  );

  for (genvar k = 0; k < MNT_NUM; k++) begin : g_mnt
    l2en_hs_chan u_chan (
      .clk   (clk),
      .rst   (rst),
      .issue (m_iss[k]),
      .ack   (mnt_ack[k]),
      .req   (mnt_req[k]),
      .fin   (mnt_fin[k])
    );
  end

  assign any_fin = reg_fin | (|mnt_fin);

endmodule

// File: rtl/l2_enable_seq_chk.sv
module l2_enable_seq_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned EN_BIT = 22,
  parameter int unsigned DC_BIT = 2,
  parameter int unsigned IC_BIT = 12,
  parameter int unsigned MN     = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_req,
  input logic          reg_we,
  input logic          reg_sel,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          reg_ack,
  input logic [MN-1:0] mnt_req,
  input logic [MN-1:0] mnt_ack,
  input logic          done
);

  logic inv_seen;
  logic en_read_set;
  logic d_on;
  logic i_on;
  logic reg_xfer;
  logic en_write;

  assign reg_xfer = reg_req && reg_ack;
  assign en_write = reg_xfer && reg_we && !reg_sel && reg_wdata[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_seen    <= 1'b0;
      en_read_set <= 1'b0;
      d_on        <= 1'b0;
      i_on        <= 1'b0;
    end else begin
      if (mnt_req[MN-1] && mnt_ack[MN-1]) inv_seen <= 1'b1;
      if (reg_xfer && !reg_we && !reg_sel && reg_rdata[EN_BIT]) en_read_set <= 1'b1;
      if (reg_xfer && reg_sel) begin
        d_on <= reg_we ? reg_wdata[DC_BIT] : reg_rdata[DC_BIT];
        i_on <= reg_we ? reg_wdata[IC_BIT] : reg_rdata[IC_BIT];
      end
    end
  end

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_req, mnt_req}) <= 1); // R8
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req); // R8
  AST_REG_FIELDS: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> $stable(reg_we) && $stable(reg_sel) && $stable(reg_wdata)); // R8
  AST_MNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mnt_req != '0) && ((mnt_req & mnt_ack) == '0) |=> $stable(mnt_req)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R9
  AST_QUIET_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !reg_req && (mnt_req == '0)); // R9
  AST_EN_AFTER_INV: assert property (@(posedge clk) disable iff (rst)
    en_write && !en_read_set |-> inv_seen); // R6
  AST_L1_OFF_AT_EN: assert property (@(posedge clk) disable iff (rst)
    en_write && !en_read_set |-> !d_on && !i_on); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !reg_req && (mnt_req == '0) && !done); // R1

endmodule

bind l2_enable_seq l2_enable_seq_chk #(
  .DW     (DW),
  .EN_BIT (EN_BIT),
  .DC_BIT (DC_BIT),
  .IC_BIT (IC_BIT),
  .MN     (l2en_pkg::MNT_NUM)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reg_ack   (reg_ack),
  .mnt_req   (mnt_req),
  .mnt_ack   (mnt_ack),
  .done      (done)
);

// File: tb/l2_enable_seq_tb.sv
module l2_enable_seq_tb;

  localparam int DW = 32;
  localparam logic [31:0] PF_M = 32'h0100_0000; // bit 24
  localparam logic [31:0] EN_M = 32'h0040_0000; // bit 22
  localparam logic [31:0] DC_M = 32'h0000_0004; // bit 2
  localparam logic [31:0] IC_M = 32'h0000_1000; // bit 12
  localparam int LOGN = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_req, reg_we, reg_sel;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata = '0;
  logic          reg_ack = 1'b0;
  logic [2:0]    mnt_req;
  logic [2:0]    mnt_ack = 3'b000;
  logic          done;

  always #5 clk = ~clk;

  l2_enable_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_ack   (reg_ack),
    .mnt_req   (mnt_req),
    .mnt_ack   (mnt_ack),
    .done      (done)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] feat_m, ctl_m;
  int lat = 0;
  int wcnt = 0;
  int overlap = 0;

  // kind: 0 read, 1 write, 2 maintenance
  int          lg_kind [LOGN];
  int          lg_sel  [LOGN];
  logic [31:0] lg_data [LOGN];
  int          lg_n = 0;

  int          ex_kind [LOGN];
  int          ex_sel  [LOGN];
  logic [31:0] ex_data [LOGN];
  string       ex_tag  [LOGN];
  int          ex_n = 0;

  task automatic log_op(input int k, input int s, input logic [31:0] d);
    if (lg_n < LOGN) begin
      lg_kind[lg_n] = k;
      lg_sel[lg_n]  = s;
      lg_data[lg_n] = d;
    end
    lg_n++;
  endtask

  // Bus responder, driven away from the active edge
  always @(negedge clk) begin
    if ($countones({reg_req, mnt_req}) > 1) overlap++;
    if (rst) begin
      reg_ack = 1'b0;
      mnt_ack = 3'b000;
      wcnt = 0;
    end else if (reg_ack || mnt_ack != 3'b000) begin
      reg_ack = 1'b0;
      mnt_ack = 3'b000;
      wcnt = 0;
    end else if (reg_req || mnt_req != 3'b000) begin
      if (wcnt >= lat) begin
        if (reg_req) begin
          if (reg_we) begin
            if (reg_sel) ctl_m = reg_wdata;
            else         feat_m = reg_wdata;
            log_op(1, int'(reg_sel), reg_wdata);
          end else begin
            reg_rdata = reg_sel ? ctl_m : feat_m;
            log_op(0, int'(reg_sel), reg_rdata);
          end
          reg_ack = 1'b1;
        end else begin
          for (int k = 0; k < 3; k++) begin
            if (mnt_req[k]) begin
              log_op(2, k, 32'h0);
              break;
            end
          end
          mnt_ack = mnt_req;
        end
      end else begin
        wcnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int s, input logic [31:0] d, input string tag);
    ex_kind[ex_n] = k;
    ex_sel[ex_n]  = s;
    ex_data[ex_n] = d;
    ex_tag[ex_n]  = tag;
    ex_n++;
  endtask

  task automatic build_exp(input logic [31:0] f0, input logic [31:0] c0,
                           output logic [31:0] f_end, output logic [31:0] c_end);
    logic [31:0] f1, c1, c2, c3;
    bit dw, iw;
    ex_n = 0;
    push(0, 0, f0, "R1");
    if ((f0 & PF_M) == 0) begin
      f1 = f0 | PF_M;
      push(1, 0, f1, "R2");
    end else begin
      f1 = f0;
    end
    push(0, 0, f1, "R3");
    f_end = f1;
    c_end = c0;
    if ((f1 & EN_M) != 0) return;
    push(0, 1, c0, "R10");
    dw = (c0 & DC_M) != 0;
    c1 = c0;
    if (dw) begin
      push(2, 0, 32'h0, "R4");
      c1 = c0 & ~DC_M;
      push(1, 1, c1, "R4");
    end
    push(0, 1, c1, "R5");
    iw = (c1 & IC_M) != 0;
    c2 = c1;
    if (iw) begin
      c2 = c1 & ~IC_M;
      push(1, 1, c2, "R5");
      push(2, 1, 32'h0, "R5");
    end
    push(2, 2, 32'h0, "R6");
    f_end = f1 | EN_M;
    push(1, 0, f_end, "R6");
    c3 = c2;
    if (iw) begin
      push(0, 1, c3, "R7");
      c3 = c3 | IC_M;
      push(1, 1, c3, "R7");
    end
    if (dw) begin
      push(0, 1, c3, "R7");
      c3 = c3 | DC_M;
      push(1, 1, c3, "R7");
    end
    c_end = c3;
  endtask

  task automatic run_case(input logic [31:0] f0, input logic [31:0] c0, input int l);
    logic [31:0] f_end, c_end;
    int cyc;
    build_exp(f0, c0, f_end, c_end);
    @(negedge clk);
    rst = 1'b1;
    feat_m = f0;
    ctl_m = c0;
    lat = l;
    lg_n = 0;
    overlap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!reg_req && mnt_req == 3'b000 && !done, "R1", "outputs in reset",
          {28'h0, reg_req, mnt_req}, 32'h0);
    rst = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(done, "R9", "done reached (watchdog)", 32'(done), 32'h1);
    repeat (5) @(negedge clk);
    check(done && !reg_req && mnt_req == 3'b000, "R9", "done sticky, ports quiet",
          {27'h0, done, reg_req, mnt_req}, 32'h10);
    check(overlap == 0, "R8", "overlapping requests", 32'(overlap), 32'h0);
    check(lg_n == ex_n, "R8", "operation count", 32'(lg_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < lg_n && i < LOGN; i++) begin
      check(lg_kind[i] == ex_kind[i] && lg_sel[i] == ex_sel[i],
            ex_tag[i], $sformatf("op %0d kind/select", i),
            32'(lg_kind[i] * 16 + lg_sel[i]), 32'(ex_kind[i] * 16 + ex_sel[i]));
      check(lg_data[i] == ex_data[i], ex_tag[i], $sformatf("op %0d data", i),
            lg_data[i], ex_data[i]);
    end
    check(feat_m == f_end, "R6", "final feature value", feat_m, f_end);
    check(ctl_m == c_end, "R7", "final control value", ctl_m, c_end);
  endtask

  initial begin
    logic [31:0] f0, c0;
    for (int l = 0; l < 3; l++) begin
      for (int m = 0; m < 16; m++) begin
        f0 = (32'h3C5A_96E1 ^ (32'(m + l * 16) * 32'h0101_0101)) & ~(PF_M | EN_M);
        c0 = (32'h0000_5078 ^ 32'(m * 32'h0000_0111)) & ~(DC_M | IC_M);
        if (m[0]) f0 = f0 | PF_M;
        if (m[1]) f0 = f0 | EN_M;
        if (m[2]) c0 = c0 | DC_M;
        if (m[3]) c0 = c0 | IC_M;
        run_case(f0, c0, l);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule